// File: doc/BRIEF.md
# Debug Trigger Register File

This block holds the machine-mode register set that configures hardware breakpoint and watchpoint triggers in a small processor core. A single CSR port, with an address, a write enable, write data and combinational read data, reaches a trigger selector, a control word and a compare value for each trigger, a third data slot that always reads as zero, and a read-only capability word. The control and compare words go through the selector, so software first picks a trigger and then programs it.

Each control-word write passes through a legalisation step, and only supported field values are stored. The type field is forced to the address/data-match type, the debug-mode-only bit is cleared, every field that is not implemented is cleared, and a size code that is not supported falls back to "any size". The privilege-enable and access-kind bits are stored unchanged. The stored control and compare words of every trigger go out on flat buses to a separate match unit. The data width is a parameter of 32 or 64.

Top module: `dbg_trig_csr`

## Requirements
- R1: After reset the selector reads 0, every control word reads type 2 with all other bits zero, and every compare value reads 0.
- R2: A selector write (address 0x7A0) takes effect only when the written value is below NUM_TRIG (2). Otherwise the selector keeps its old value.
- R3: The type field of every stored control word (bits [XLEN-1:XLEN-4]) always reads 2, and bit XLEN-5 (debug-mode only) always reads 0, whatever value is written.
- R4: The control-word bits for match, chain, action ([15:12]), timing, select, hit and bit 5 always read 0 after any write. Only bits 0-4, 6, [17:16], [22:21] (XLEN=64 only) and the type field can be non-zero.
- R5: The size code is {bits[22:21], bits[17:16]} when XLEN=64, and {2'b00, bits[17:16]} when XLEN=32. Codes 0, 1, 2, 3 and 5 are stored as written. Any other code stores size bits of 0.
- R6: The access bits load (0), store (1) and execute (2) and the privilege bits U (3), S (4) and M (6) are stored exactly as written.
- R7: Control (0x7A1) and compare (0x7A2) accesses reach the trigger chosen by the selector. A compare write stores all XLEN bits. Trigger i is exported on trig_ctrl_o and trig_cmp_o in slice [i*XLEN +: XLEN].
- R8: The third data slot (0x7A3) always reads 0, and writes to it change nothing.
- R9: The capability word (0x7A4) always reads 0x4 (only type 2 supported), and writes to it change nothing.
- R10: Reads of any other address return 0, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | Write enable, one write per cycle |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data for csr_addr_i |
| trig_ctrl_o | output | NUM_TRIG*XLEN | Stored control words, one per trigger |
| trig_cmp_o | output | NUM_TRIG*XLEN | Stored compare values, one per trigger |

## Verification
The assertions assume that csr_addr_i, csr_we_i and csr_wdata_i are known and steady around each rising edge, and that a read is judged only while csr_we_i is low. The stability checks on the exported words rely on the fact that only a write to the control or compare address can change them. The bench changes inputs only on falling edges and samples read data a quarter period later, with the write enable low. Illegal size codes are only reachable at XLEN=64, so a second instance at that width covers them.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
    localparam logic [11:0] CSR_SEL   = 12'h7A0;
    localparam logic [11:0] CSR_CTRL  = 12'h7A1;
    localparam logic [11:0] CSR_CMP   = 12'h7A2;
    localparam logic [11:0] CSR_AUX   = 12'h7A3;
    localparam logic [11:0] CSR_CAPS  = 12'h7A4;
    localparam logic [3:0]  TYPE_ADDR_MATCH = 4'd2;
    // load, store, exec, U, S at [4:0]; M at 6
    localparam logic [6:0]  KEEP_LOW  = 7'h5F;
endpackage

// File: rtl/dbg_trig_legal.sv
module dbg_trig_legal #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] wr_i,
    output logic [XLEN-1:0] legal_o
);
    import dbg_trig_pkg::*;

    logic [1:0] size_hi;
    logic [3:0] size_code;
    logic       size_ok;

    generate
        if (XLEN == 64) begin : g_wide
            assign size_hi = wr_i[22:21];
        end else begin : g_narrow
            assign size_hi = 2'b00;
        end
    endgenerate

    assign size_code = {size_hi, wr_i[17:16]};
    assign size_ok   = (size_code inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5});

    always_comb begin
        legal_o = '0;
        legal_o[XLEN-1 -: 4] = TYPE_ADDR_MATCH;
        legal_o[6:0] = wr_i[6:0] & KEEP_LOW;
        if (size_ok) begin
            legal_o[17:16] = wr_i[17:16];
            if (XLEN == 64) begin
                legal_o[22:21] = size_hi;
            end
        end
    end
endmodule

// File: rtl/dbg_trig_rdmux.sv
module dbg_trig_rdmux #(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2,
    parameter int SEL_W    = 1
) (
    input  logic [11:0]              addr_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [NUM_TRIG*XLEN-1:0] ctrl_i,
    input  logic [NUM_TRIG*XLEN-1:0] cmp_i,
    output logic [XLEN-1:0]          rdata_o
);
    import dbg_trig_pkg::*;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            CSR_SEL:  rdata_o = XLEN'(sel_i);
            CSR_CTRL: rdata_o = ctrl_i[int'(sel_i)*XLEN +: XLEN];
            CSR_CMP:  rdata_o = cmp_i[int'(sel_i)*XLEN +: XLEN];
            CSR_CAPS: rdata_o = XLEN'(1) << TYPE_ADDR_MATCH;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dbg_trig_csr.sv
module dbg_trig_csr #(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [11:0]              csr_addr_i,
    input  logic                     csr_we_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic [XLEN-1:0]          csr_rdata_o,
    output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
    output logic [NUM_TRIG*XLEN-1:0] trig_cmp_o
);
    import dbg_trig_pkg::*;

    localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
    localparam logic [XLEN-1:0] CTRL_RST = {TYPE_ADDR_MATCH, {(XLEN-4){1'b0}}};

    typedef struct packed {
        logic [SEL_W-1:0]                sel;
        logic [NUM_TRIG-1:0][XLEN-1:0]   ctrl;
        logic [NUM_TRIG-1:0][XLEN-1:0]   cmp;
    } state_t;

    state_t st_d, st_q;
    logic [XLEN-1:0] legal_w;

    dbg_trig_legal #(.XLEN(XLEN)) legal_i (
        .wr_i    (csr_wdata_i),
        .legal_o (legal_w)
    );

    always_comb begin
        st_d = st_q;
        if (csr_we_i) begin
            case (csr_addr_i)
                CSR_SEL: begin
                    if (csr_wdata_i < XLEN'(NUM_TRIG)) begin
                        st_d.sel = csr_wdata_i[SEL_W-1:0];
                    end
                end
                CSR_CTRL: st_d.ctrl[st_q.sel] = legal_w;
                CSR_CMP:  st_d.cmp[st_q.sel]  = csr_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sel <= '0;
            for (int i = 0; i < NUM_TRIG; i++) begin
                st_q.ctrl[i] <= CTRL_RST;
                st_q.cmp[i]  <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_ctrl_o = st_q.ctrl;
    assign trig_cmp_o  = st_q.cmp;

    dbg_trig_rdmux #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) rdmux_i (
        .addr_i  (csr_addr_i),
        .sel_i   (st_q.sel),
        .ctrl_i  (trig_ctrl_o),
        .cmp_i   (trig_cmp_o),
        .rdata_o (csr_rdata_o)
    );
endmodule

// File: rtl/dbg_trig_csr_chk.sv
module dbg_trig_csr_chk #(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [11:0]              csr_addr_i,
    input logic                     csr_we_i,
    input logic [XLEN-1:0]          csr_wdata_i,
    input logic [XLEN-1:0]          csr_rdata_o,
    input logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
    input logic [NUM_TRIG*XLEN-1:0] trig_cmp_o
);
    localparam logic [XLEN-1:0] SZ_MASK =
        (XLEN == 64) ? XLEN'(32'h0063_0000) : XLEN'(32'h0003_0000);
    localparam logic [XLEN-1:0] ALLOW =
        SZ_MASK | XLEN'(32'h0000_005F) | {4'hF, {(XLEN-4){1'b0}}};

    function automatic logic [3:0] size_of(input logic [XLEN-1:0] w);
        if (XLEN == 64) return {w[22:21], w[17:16]};
        else            return {2'b00, w[17:16]};
    endfunction

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        logic [XLEN-1:0] c;
        assign c = trig_ctrl_o[t*XLEN +: XLEN];

        // R3
        type_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            c[XLEN-1 -: 5] == 5'b00100);
        // R4
        unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c & ~ALLOW) == '0);
        // R5
        size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            size_of(c) inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5});
    end

    // R9
    caps_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h7A4) |-> (csr_rdata_o == XLEN'(4)));
    // R8
    aux_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == 12'h7A3) |-> (csr_rdata_o == '0));
    // R7
    cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(csr_we_i && csr_addr_i == 12'h7A2) |=> $stable(trig_cmp_o));
    // R10
    ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(csr_we_i && csr_addr_i == 12'h7A1) |=> $stable(trig_ctrl_o));
endmodule

bind dbg_trig_csr dbg_trig_csr_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_addr_i  (csr_addr_i),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .trig_ctrl_o (trig_ctrl_o),
    .trig_cmp_o  (trig_cmp_o)
);

// File: tb/dbg_trig_csr_tb_top.sv
module dbg_trig_csr_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [11:0] a32, a64;
    logic        we32, we64;
    logic [31:0] wd32, rd32;
    logic [63:0] wd64, rd64;
    logic [63:0] ctrl32, cmp32;
    logic [127:0] ctrl64, cmp64;

    dbg_trig_csr #(.XLEN(32), .NUM_TRIG(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(a32), .csr_we_i(we32),
        .csr_wdata_i(wd32), .csr_rdata_o(rd32),
        .trig_ctrl_o(ctrl32), .trig_cmp_o(cmp32));

    dbg_trig_csr #(.XLEN(64), .NUM_TRIG(2)) dut64_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(a64), .csr_we_i(we64),
        .csr_wdata_i(wd64), .csr_rdata_o(rd64),
        .trig_ctrl_o(ctrl64), .trig_cmp_o(cmp64));

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [11:0] a;
        logic        we;
        logic [31:0] wd;
        logic [31:0] ex;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{12'h7A0, 1'b0, 32'h0,         32'h0,         4'd1},  // R1 selector
        '{12'h7A1, 1'b0, 32'h0,         32'h2000_0000, 4'd1},  // R1 control
        '{12'h7A4, 1'b0, 32'h0,         32'h4,         4'd9},  // R9
        '{12'h7A1, 1'b1, 32'hFFFF_FFFF, 32'h0,         4'd3},
        '{12'h7A1, 1'b0, 32'h0,         32'h2003_005F, 4'd3},  // R3 R4 R6
        '{12'h7A2, 1'b1, 32'hDEAD_BEEF, 32'h0,         4'd7},
        '{12'h7A2, 1'b0, 32'h0,         32'hDEAD_BEEF, 4'd7},  // R7
        '{12'h7A0, 1'b1, 32'h1,         32'h0,         4'd2},
        '{12'h7A0, 1'b0, 32'h0,         32'h1,         4'd2},  // R2 accepted
        '{12'h7A1, 1'b0, 32'h0,         32'h2000_0000, 4'd7},  // R7 entry 1 untouched
        '{12'h7A1, 1'b1, 32'h0000_F0A5, 32'h0,         4'd4},
        '{12'h7A1, 1'b0, 32'h0,         32'h2000_0005, 4'd4},  // R4
        '{12'h7A0, 1'b1, 32'h2,         32'h0,         4'd2},
        '{12'h7A0, 1'b0, 32'h0,         32'h1,         4'd2},  // R2 ignored
        '{12'h7A0, 1'b1, 32'h0,         32'h0,         4'd2},
        '{12'h7A1, 1'b0, 32'h0,         32'h2003_005F, 4'd7},  // R7 entry 0 kept
        '{12'h7A3, 1'b1, 32'h1234_5678, 32'h0,         4'd8},
        '{12'h7A3, 1'b0, 32'h0,         32'h0,         4'd8},  // R8
        '{12'h7A4, 1'b1, 32'hFFFF_FFFF, 32'h0,         4'd9},
        '{12'h7A4, 1'b0, 32'h0,         32'h4,         4'd9},  // R9
        '{12'h7A5, 1'b1, 32'h0000_FFFF, 32'h0,         4'd10},
        '{12'h7A5, 1'b0, 32'h0,         32'h0,         4'd10}, // R10
        '{12'h7A1, 1'b1, 32'h0002_0048, 32'h0,         4'd6},
        '{12'h7A1, 1'b0, 32'h0,         32'h2002_0048, 4'd6}   // R5 R6
    };

    task automatic op64(input logic [11:0] a, input logic we, input logic [63:0] wd,
                        input logic [63:0] ex, input int req);
        @(negedge clk);
        a64 = a; we64 = we; wd64 = wd;
        #5;
        if (!we) check(req, rd64, ex);
    endtask

    initial begin
        a32 = '0; we32 = 1'b0; wd32 = '0;
        a64 = '0; we64 = 1'b0; wd64 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a32 = VEC[i].a; we32 = VEC[i].we; wd32 = VEC[i].wd;
            #5;
            if (!VEC[i].we) check(int'(VEC[i].rq), 64'(rd32), 64'(VEC[i].ex));
        end
        @(negedge clk);
        we32 = 1'b0; a32 = '0;
        #5;
        // R7 exported slices
        check(7, 64'(ctrl32[31:0]),  64'h2002_0048);
        check(7, 64'(ctrl32[63:32]), 64'h2000_0005);
        check(7, 64'(cmp32[31:0]),   64'hDEAD_BEEF);
        check(7, 64'(cmp32[63:32]),  64'h0);

        // R5 at XLEN=64: code 4 illegal
        op64(12'h7A1, 1'b1, 64'h0000_0000_0020_0000, 0, 5);
        op64(12'h7A1, 1'b0, 0, 64'h2000_0000_0000_0000, 5);
        // R5 code 5 kept, with load bit
        op64(12'h7A1, 1'b1, 64'h0000_0000_0021_0001, 0, 5);
        op64(12'h7A1, 1'b0, 0, 64'h2000_0000_0021_0001, 5);
        // R5 code 12 illegal
        op64(12'h7A1, 1'b1, 64'h0000_0000_0060_0000, 0, 5);
        op64(12'h7A1, 1'b0, 0, 64'h2000_0000_0000_0000, 5);
        // R3 R4 all ones at XLEN=64 (code 15 illegal)
        op64(12'h7A1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 3);
        op64(12'h7A1, 1'b0, 0, 64'h2000_0000_0000_005F, 3);
        // R7 full-width compare
        op64(12'h7A2, 1'b1, 64'hF00D_CAFE_1234_5678, 0, 7);
        op64(12'h7A2, 1'b0, 0, 64'hF00D_CAFE_1234_5678, 7);
        op64(12'h7A4, 1'b0, 0, 64'h4, 9);

        // R1 reset again mid-run
        @(negedge clk);
        we64 = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        a32 = 12'h7A2;
        #5;
        check(1, 64'(rd32), 64'h0);
        check(1, ctrl64[63:0], 64'h2000_0000_0000_0000);
        check(1, cmp32, 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule